// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits on the write path of an embedded flash. It watches every write cycle aimed at the array and picks out the unlock prefixes and command codes. When a sequence completes, it raises a one-cycle operation request for the erase/program engine. Any write that breaks a sequence sends the block back to read mode, and no request is made for it.

The block owns the erase-confirm window. After a block erase is confirmed, further confirm writes add blocks to a mask and restart the window. The erase is launched only after `WIN_US` microsecond ticks pass with no new confirm. Two status inputs from the engine decide which commands are legal: `flash_busy` (an erase is running) and `flash_susp` (an erase is suspended).

The write input is a plain strobe. The block accepts one write on every cycle that `wr_valid` is high and never applies back-pressure, so there is no ready signal. Requests leave on `op_valid` as single-cycle pulses and are not held.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `op_valid` and `win_open` are low and the block is in read mode.
- R2: Addresses are compared on bits 13:0 only and data on bits 7:0 only. The command prefix is A8h at 1554h, then 54h at 2AA8h. The protection prefix is A8h at 2A54h, then 54h at 15A8h.
- R3: Program word is the command prefix, then A0h at 1554h. The next write of any value is the payload. One cycle after the payload write, the block pulses operation code 1 with `op_addr`/`op_data` equal to that write.
- R4: Block erase is the command prefix, 80h at 1554h, the command prefix again, then 30h. That 30h opens the window (`win_open` high) and sets the mask bit for block `wr_addr[BLK_LSB +: BLK_W]`. Each further 30h while the window is open ORs in its block and restarts the count. After `WIN_US` consecutive ticks with no confirm, the block pulses code 2, and `op_blk_mask` carries the collected mask. `op_blk_mask` is zero for every other code.
- R5: Chip erase uses 10h in place of the first 30h. It pulses code 3 and does not open the window.
- R6: F0h at any address, with or without the command prefix, pulses code 6 and returns to read mode. In the window, it closes the window and no erase is launched.
- R7: While `flash_busy` is high, B0h at any address pulses code 4. B0h in the window launches the erase (code 2) and pulses code 4 on the next cycle.
- R8: While `flash_susp` is high, 30h at any address pulses code 5.
- R9: While busy, every write except B0h and F0h is ignored. While suspended, only 30h and the program word sequence are accepted; F0h and erase setup make no request.
- R10: After the protection prefix, the write at 2A54h selects the operation. C0h takes the next write as payload and pulses code 7 with its address and data. 90h pulses code 8. C1h pulses code 9.
- R11: A write with an unexpected address or data inside a sequence aborts it with no request. The next sequence then works from its first cycle.
- R12: Each request is a single-cycle pulse of `op_valid`, and `op_code` is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_valid | input | 1 | Write cycle strobe, always accepted |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 16 | Write data |
| flash_busy | input | 1 | Erase is running |
| flash_susp | input | 1 | Erase is suspended |
| op_valid | output | 1 | Request pulse |
| op_code | output | 4 | Request code (see R3 to R10) |
| op_addr | output | ADDR_W | Address of the write that completed the request |
| op_data | output | 16 | Data of that write |
| op_blk_mask | output | NBLK | Blocks to erase, with code 2 only |
| win_open | output | 1 | Erase-confirm window is open |

## Verification
The bench tries clean sequences whose upper address and data bits are set to noise. A request on these shows that the comparison masks off the bits it should. Erase is run in three forms: with one block, with two blocks where the second confirm arrives late, and with a suspend or reset inside the window. These tell the restart of the window apart from a window that expires on its first count, and a launched erase from a dropped one. The same writes are repeated with `flash_busy` and with `flash_susp` high, which separates commands that are gated from those that are accepted. Corrupted middle cycles are each followed by a clean sequence, which shows that an abort leaves no stale state behind.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_PROG     = 4'd1,
    OP_BERASE   = 4'd2,
    OP_CERASE   = 4'd3,
    OP_SUSP     = 4'd4,
    OP_RESUME   = 4'd5,
    OP_RESET    = 4'd6,
    OP_SETPROT  = 4'd7,
    OP_RDPROT   = 4'd8,
    OP_TMPUNP   = 4'd9
  } op_e;

  typedef enum logic [3:0] {
    S_READ, S_CU1, S_CU2, S_PGM, S_ER1, S_ER2, S_ER3,
    S_WIN, S_PU1, S_PU2, S_PRT
  } st_e;

  localparam int KEY_W = 14;
  localparam logic [KEY_W-1:0] K_CMD_A  = 14'h1554;
  localparam logic [KEY_W-1:0] K_CMD_B  = 14'h2AA8;
  localparam logic [KEY_W-1:0] K_PROT_A = 14'h2A54;
  localparam logic [KEY_W-1:0] K_PROT_B = 14'h15A8;

  localparam logic [7:0] C_UNLK_A  = 8'hA8;
  localparam logic [7:0] C_UNLK_B  = 8'h54;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ESETUP  = 8'h80;
  localparam logic [7:0] C_CONFIRM = 8'h30;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_SETPROT = 8'hC0;
  localparam logic [7:0] C_RDPROT  = 8'h90;
  localparam logic [7:0] C_TMPUNP  = 8'hC1;

endpackage

// File: rtl/flash_cmd_decode.sv
`timescale 1ns/1ps
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [KEY_W-1:0] key_addr,
  input  logic [7:0]       key_data,
  output logic             pfx_cmd_a,
  output logic             pfx_cmd_b,
  output logic             pfx_prot_a,
  output logic             pfx_prot_b,
  output logic             at_cmd,
  output logic             at_prot
);
  logic at_cmd_b, at_prot_b;

  always_comb begin
    at_cmd     = (key_addr == K_CMD_A);
    at_cmd_b   = (key_addr == K_CMD_B);
    at_prot    = (key_addr == K_PROT_A);
    at_prot_b  = (key_addr == K_PROT_B);
    pfx_cmd_a  = at_cmd    && (key_data == C_UNLK_A);
    pfx_cmd_b  = at_cmd_b  && (key_data == C_UNLK_B);
    pfx_prot_a = at_prot   && (key_data == C_UNLK_A);
    pfx_prot_b = at_prot_b && (key_data == C_UNLK_B);
  end
endmodule

// File: rtl/flash_erase_window.sv
`timescale 1ns/1ps
module flash_erase_window #(
  parameter int NBLK   = 8,
  parameter int WIN_US = 96,
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CNT_W = (WIN_US > 1) ? $clog2(WIN_US) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            add,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic            run,
  input  logic            tick,
  output logic [NBLK-1:0] mask,
  output logic            expire
);
  logic [NBLK-1:0]  sel;
  logic [CNT_W-1:0] cnt;

  for (genvar g = 0; g < NBLK; g++) begin : g_sel
    assign sel[g] = (blk_idx == BLK_W'(g));
  end

  assign expire = run && tick && !(start || add) && (cnt == CNT_W'(WIN_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      cnt  <= '0;
    end else begin
      if (start) begin
        mask <= sel;
        cnt  <= '0;
      end else if (add) begin
        mask <= mask | sel;
        cnt  <= '0;
      end else if (run && tick && !expire) begin
        cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              pfx_cmd_a,
  input  logic              pfx_cmd_b,
  input  logic              pfx_prot_a,
  input  logic              pfx_prot_b,
  input  logic              at_cmd,
  input  logic              at_prot,
  input  logic              flash_busy,
  input  logic              flash_susp,
  input  logic              win_expire,
  output logic              win_start,
  output logic              win_add,
  output logic              win_run,
  output logic              op_valid,
  output op_e               op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data
);
  st_e        st, st_n;
  op_e        op_n;
  logic       pend, pend_n;
  logic [7:0] b;

  assign b       = wr_data[7:0];
  assign win_run = (st == S_WIN);

  always_comb begin
    st_n      = st;
    op_n      = OP_NONE;
    pend_n    = 1'b0;
    win_start = 1'b0;
    win_add   = 1'b0;
    if (wr_valid) begin
      unique case (st)
        S_PGM: begin op_n = OP_PROG;    st_n = S_READ; end
        S_PRT: begin op_n = OP_SETPROT; st_n = S_READ; end
        default: begin
          if (b == C_RESET && !flash_susp) begin
            op_n = OP_RESET;
            st_n = S_READ;
          end else begin
            st_n = S_READ;
            case (st)
              S_READ: begin
                if (flash_busy) begin
                  if (b == C_SUSP) op_n = OP_SUSP;
                end else if (flash_susp) begin
                  if (b == C_CONFIRM) op_n = OP_RESUME;
                  else if (pfx_cmd_a) st_n = S_CU1;
                end else if (pfx_cmd_a) begin
                  st_n = S_CU1;
                end else if (pfx_prot_a) begin
                  st_n = S_PU1;
                end
              end
              S_CU1: if (pfx_cmd_b) st_n = S_CU2;
              S_CU2: begin
                if (at_cmd && b == C_PROG) st_n = S_PGM;
                else if (at_cmd && b == C_ESETUP && !flash_susp) st_n = S_ER1;
              end
              S_ER1: if (pfx_cmd_a) st_n = S_ER2;
              S_ER2: if (pfx_cmd_b) st_n = S_ER3;
              S_ER3: begin
                if (b == C_CONFIRM) begin
                  win_start = 1'b1;
                  st_n      = S_WIN;
                end else if (b == C_CHIP) begin
                  op_n = OP_CERASE;
                end
              end
              S_WIN: begin
                if (b == C_CONFIRM) begin
                  win_add = 1'b1;
                  st_n    = S_WIN;
                end else if (b == C_SUSP) begin
                  op_n   = OP_BERASE;
                  pend_n = 1'b1;
                end
              end
              S_PU1: if (pfx_prot_b) st_n = S_PU2;
              S_PU2: begin
                if (at_prot && b == C_SETPROT)     st_n = S_PRT;
                else if (at_prot && b == C_RDPROT) op_n = OP_RDPROT;
                else if (at_prot && b == C_TMPUNP) op_n = OP_TMPUNP;
              end
              default: st_n = S_READ;
            endcase
          end
        end
      endcase
    end else if (st == S_WIN && win_expire) begin
      op_n = OP_BERASE;
      st_n = S_READ;
    end
    if (pend) op_n = OP_SUSP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_READ;
      pend     <= 1'b0;
      op_valid <= 1'b0;
      op_code  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      st       <= st_n;
      pend     <= pend_n;
      op_valid <= (op_n != OP_NONE);
      op_code  <= op_n;
      if (wr_valid && op_n != OP_NONE) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int NBLK    = 8,
  parameter int BLK_LSB = 16,
  parameter int WIN_US  = 96,
  localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              flash_busy,
  input  logic              flash_susp,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data,
  output logic [NBLK-1:0]   op_blk_mask,
  output logic              win_open
);
  logic pfx_cmd_a, pfx_cmd_b, pfx_prot_a, pfx_prot_b, at_cmd, at_prot;
  logic win_start, win_add, win_run, win_expire;
  logic [NBLK-1:0] mask;
  op_e  code;

  flash_cmd_decode u_dec (
    .key_addr   (wr_addr[KEY_W-1:0]),
    .key_data   (wr_data[7:0]),
    .pfx_cmd_a  (pfx_cmd_a),
    .pfx_cmd_b  (pfx_cmd_b),
    .pfx_prot_a (pfx_prot_a),
    .pfx_prot_b (pfx_prot_b),
    .at_cmd     (at_cmd),
    .at_prot    (at_prot)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pfx_cmd_a  (pfx_cmd_a),
    .pfx_cmd_b  (pfx_cmd_b),
    .pfx_prot_a (pfx_prot_a),
    .pfx_prot_b (pfx_prot_b),
    .at_cmd     (at_cmd),
    .at_prot    (at_prot),
    .flash_busy (flash_busy),
    .flash_susp (flash_susp),
    .win_expire (win_expire),
    .win_start  (win_start),
    .win_add    (win_add),
    .win_run    (win_run),
    .op_valid   (op_valid),
    .op_code    (code),
    .op_addr    (op_addr),
    .op_data    (op_data)
  );

  flash_erase_window #(.NBLK(NBLK), .WIN_US(WIN_US)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (win_start),
    .add     (win_add),
    .blk_idx (wr_addr[BLK_LSB +: BLK_W]),
    .run     (win_run),
    .tick    (us_tick),
    .mask    (mask),
    .expire  (win_expire)
  );

  assign op_code     = code;
  assign win_open    = win_run;
  assign op_blk_mask = (op_valid && code == OP_BERASE) ? mask : '0;
endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk #(
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flash_busy,
  input logic            flash_susp,
  input logic            op_valid,
  input logic [3:0]      op_code,
  input logic [NBLK-1:0] op_blk_mask,
  input logic            win_open
);
  a_r9_no_prog_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd1) |-> !$past(flash_busy));

  a_r8_resume_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd5) |-> $past(flash_susp));

  a_r4_erase_has_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd2) |-> (op_blk_mask != '0));

  a_r4_erase_from_window: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd2) |-> ($past(win_open) && !win_open));

  a_r5_chip_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd3) |-> (!win_open && !$past(win_open)));

  a_r12_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (op_code == 4'd0));
endmodule

bind flash_cmd_seq flash_cmd_chk #(.NBLK(NBLK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flash_busy  (flash_busy),
  .flash_susp  (flash_susp),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .op_blk_mask (op_blk_mask),
  .win_open    (win_open)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int AW  = 19;
  localparam int NB  = 8;
  localparam int WIN = 12;

  logic clk = 0, rst_n = 0, us_tick = 1, wr_valid = 0, busy = 0, susp = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic op_valid, win_open;
  logic [3:0] op_code;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data;
  logic [NB-1:0] op_blk_mask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .NBLK(NB), .BLK_LSB(16), .WIN_US(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .flash_busy(busy), .flash_susp(susp),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .op_blk_mask(op_blk_mask), .win_open(win_open));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write cycle; returns at the negedge after the capturing edge
  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic expect_op(string tag, logic [3:0] code);
    check({tag, " valid"}, {31'd0, op_valid}, {31'd0, code != 0});
    check({tag, " code"}, {28'd0, op_code}, {28'd0, code});
  endtask

  task automatic cmd_pfx(); wr(19'h71554, 16'h77A8); wr(19'h2AA8, 16'h0054); endtask
  task automatic prot_pfx(); wr(19'h2A54, 16'h00A8); wr(19'h15A8, 16'h0054); endtask

  task automatic erase_setup();
    cmd_pfx(); wr(19'h1554, 16'h0080); cmd_pfx();
  endtask

  task automatic t_reset();
    check("R1 op_valid", {31'd0, op_valid}, 0);
    check("R1 win_open", {31'd0, win_open}, 0);
  endtask

  task automatic t_program();
    cmd_pfx(); wr(19'h45554, 16'h3CA0);           // upper bits are noise (R2)
    expect_op("R3 no op before payload", 0);
    wr(19'h2_0102, 16'hBEEF);
    expect_op("R3 R2 program", 1);
    check("R3 addr", {13'd0, op_addr}, {13'd0, 19'h2_0102});
    check("R3 data", {16'd0, op_data}, 32'hBEEF);
    @(negedge clk);
    expect_op("R12 pulse ends", 0);
  endtask

  task automatic t_block_erase();
    erase_setup(); wr(19'h3_0000, 16'h0030);
    check("R4 window open", {31'd0, win_open}, 1);
    wr(19'h5_1234, 16'h0030);
    repeat (WIN - 1) @(negedge clk);
    expect_op("R4 not yet", 0);
    check("R4 still open", {31'd0, win_open}, 1);
    @(negedge clk);
    expect_op("R4 launch", 2);
    check("R4 mask", {24'd0, op_blk_mask}, 32'h28);
    check("R4 window closed", {31'd0, win_open}, 0);
    // restart: late second confirm
    erase_setup(); wr(19'h1_0000, 16'h0030);
    repeat (WIN - 4) @(negedge clk);
    wr(19'h2_0000, 16'h0030);
    repeat (WIN - 1) @(negedge clk);
    expect_op("R4 restarted", 0);
    @(negedge clk);
    expect_op("R4 launch after restart", 2);
    check("R4 mask2", {24'd0, op_blk_mask}, 32'h06);
  endtask

  task automatic t_chip();
    erase_setup(); wr(19'h0, 16'h0010);
    expect_op("R5 chip erase", 3);
    check("R5 no window", {31'd0, win_open}, 0);
    check("R4 mask zero other code", {24'd0, op_blk_mask}, 0);
  endtask

  task automatic t_reset_cmd();
    wr(19'h1234, 16'h00F0);
    expect_op("R6 bare reset", 6);
    cmd_pfx(); wr(19'h0777, 16'hAAF0);
    expect_op("R6 prefixed reset", 6);
    erase_setup(); wr(19'h4_0000, 16'h0030);
    wr(19'h0, 16'h00F0);
    expect_op("R6 reset in window", 6);
    check("R6 window closed", {31'd0, win_open}, 0);
    repeat (WIN + 2) begin
      @(negedge clk);
      check("R6 no erase", {31'd0, op_valid}, 0);
    end
  endtask

  task automatic t_suspend();
    busy = 1;
    wr(19'h3333, 16'h00B0);
    expect_op("R7 suspend busy", 4);
    busy = 0;
    wr(19'h3333, 16'h00B0);
    expect_op("R7 B0 idle ignored", 0);
    erase_setup(); wr(19'h6_0000, 16'h0030);
    wr(19'h0, 16'h00B0);
    expect_op("R7 erase on B0", 2);
    check("R7 mask", {24'd0, op_blk_mask}, 32'h40);
    @(negedge clk);
    expect_op("R7 suspend follows", 4);
  endtask

  task automatic t_resume_legal();
    susp = 1;
    wr(19'h5555, 16'h0030);
    expect_op("R8 resume", 5);
    wr(19'h0, 16'h00F0);
    expect_op("R9 reset ignored suspended", 0);
    cmd_pfx(); wr(19'h1554, 16'h0080);
    cmd_pfx(); wr(19'h0, 16'h0010);
    expect_op("R9 erase refused suspended", 0);
    cmd_pfx(); wr(19'h1554, 16'h00A0); wr(19'h123, 16'h0F0F);
    expect_op("R9 program in suspend", 1);
    susp = 0; busy = 1;
    cmd_pfx(); wr(19'h1554, 16'h00A0); wr(19'h123, 16'h0F0F);
    expect_op("R9 program refused busy", 0);
    wr(19'h0, 16'h0030);
    expect_op("R9 resume refused busy", 0);
    wr(19'h0, 16'h00F0);
    expect_op("R9 reset while busy", 6);
    busy = 0;
  endtask

  task automatic t_prot();
    prot_pfx(); wr(19'h2A54, 16'h00C0);
    expect_op("R10 no op before payload", 0);
    wr(19'h0042, 16'h00FE);
    expect_op("R10 set protection", 7);
    check("R10 data", {16'd0, op_data}, 32'h00FE);
    prot_pfx(); wr(19'h2A54, 16'h0090);
    expect_op("R10 read status", 8);
    prot_pfx(); wr(19'h2A54, 16'h00C1);
    expect_op("R10 temp unprotect", 9);
    cmd_pfx(); wr(19'h2A54, 16'h0090);
    expect_op("R10 wrong prefix", 0);
  endtask

  task automatic t_abort();
    wr(19'h1554, 16'h00A8); wr(19'h2AA9, 16'h0054);
    wr(19'h1554, 16'h00A0); wr(19'h10, 16'h0011);
    expect_op("R11 bad addr aborts", 0);
    cmd_pfx(); wr(19'h1554, 16'h0081); wr(19'h10, 16'h0011);
    expect_op("R11 bad data aborts", 0);
    erase_setup(); wr(19'h1_0000, 16'h0030);
    wr(19'h0, 16'h0055);
    check("R11 window aborted", {31'd0, win_open}, 0);
    repeat (WIN + 2) @(negedge clk);
    expect_op("R11 no erase after abort", 0);
    cmd_pfx(); wr(19'h1554, 16'h00A0); wr(19'h77, 16'h1234);
    expect_op("R11 recovery", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_block_erase();
    t_chip();
    t_reset_cmd();
    t_suspend();
    t_resume_legal();
    t_prot();
    t_abort();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule